// File: doc/BRIEF.md
# Cell-Averaging CFAR Detector

This block applies a constant-false-alarm-rate test to one frame of unsigned magnitude samples taken from a range-Doppler map. Samples stream in one per accepted cycle until a whole frame sits in an internal buffer. The block then walks every cell in index order. For each cell under test it sums the training cells on the leading side (lower indices) and on the lagging side (higher indices), skipping the guard cells next to the cell. It combines the two sides into a noise estimate in one of three ways, scales that estimate by a programmable factor, and emits one result per cell. The result carries a hit flag and the cell's index.

Averages are never divided out. The test is rearranged so that only products are compared: the cell magnitude times the training-cell count, shifted left by the fraction width of the scale factor, is compared with the scale factor times the training sum. Greatest-of and smallest-of selection works the same way, comparing each side sum multiplied by the other side's count. Near the frame edges the training windows are cut short to stay inside the buffer, and each side's count drops to match.

The selected noise sum and count are held in a register, and the threshold compare uses them on a later cycle. Mode, scale factor, guard size and training size are sampled when the frame's last sample is accepted. They hold for the whole evaluation pass.

Top module: `cfar_detect`

## Requirements
- R1: After reset, and whenever `enable` is low, `busy` and `outValid` are 0 and samples are not stored. Dropping `enable` during a partial frame discards it, and the next accepted sample becomes cell 0.
- R2: After FRAME_LEN accepted samples, `busy` rises. Exactly one `outValid` pulse then follows for each cell, with `outIndex` running 0 to FRAME_LEN-1 in order. `busy` falls when the last result is issued.
- R3: While `busy` is high, `inValid` is ignored. Neither the frame under test nor the next frame is changed.
- R4: For cell c, the training cells are the cells at distances `guardLen`+1 through `guardLen`+`trainLen` on each side. The `guardLen` cells nearest c on each side, and c itself, are in neither sum.
- R5: A training position that falls below index 0 or beyond FRAME_LEN-1 is skipped, and that side's cell count is reduced by one.
- R6: With `modeSel` = 0 (cell-averaging), or 3 (treated the same way), the noise sum is the sum of both sides and the count is the total count of both sides.
- R7: With `modeSel` = 1 (greatest-of), the side with the larger average is used; with 2 (smallest-of), the side with the smaller average. Lead is used when leadSum*lagCnt equals lagSum*leadCnt. A side with zero count is never chosen while the other side has cells.
- R8: `outHit` is 1 exactly when mag*count*2^ALPHA_FRAC > `alpha`*sum. The comparison is strict, and `alpha` is unsigned with ALPHA_FRAC fraction bits (4 by default).
- R9: A cell whose chosen count is zero, for example with `trainLen` = 0, never reports a hit.
- R10: Changes to `modeSel`, `alpha`, `guardLen` or `trainLen` while `busy` is high do not affect the frame being evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Detector enable; low holds the block idle |
| modeSel | input | 2 | 0 cell-averaging, 1 greatest-of, 2 smallest-of, 3 cell-averaging |
| alpha | input | ALPHA_W (8) | Threshold scale, ALPHA_FRAC fraction bits |
| guardLen | input | GUARD_W (4) | Guard cells on each side |
| trainLen | input | TRAIN_W (5) | Training cells on each side |
| inValid | input | 1 | Sample strobe |
| inMag | input | MAG_W (17) | Unsigned magnitude sample |
| busy | output | 1 | Evaluation pass in progress; input blocked |
| outValid | output | 1 | One-cycle result strobe |
| outHit | output | 1 | Cell exceeds threshold |
| outIndex | output | ADDR_W (11) | Cell position in the frame |

## Verification
A wrong write pointer or a leaked write while busy would shift or corrupt stored cells. That shows up as hit flags that disagree with the reference at the affected indices, in the same frame or the next one. A wrong training offset, edge count or side selection flips hit decisions on the spiked, ramped and stepped frames within the pass. Edge cells expose count errors first. A faulty cell counter or emit sequencing shows at once as an out-of-order `outIndex`, a missing or extra result, or `busy` staying high.

// File: rtl/cfar_detect_pkg.sv
package cfar_detect_pkg;

  typedef enum logic [1:0] {
    MODE_AVG    = 2'd0,
    MODE_MAX    = 2'd1,
    MODE_MIN    = 2'd2,
    MODE_AVG_B  = 2'd3
  } noise_mode_e;

  typedef struct packed {
    logic wrEn;
    logic clearAcc;
    logic accumulate;
    logic crossStb;
    logic pickStb;
    logic cmpStb;
    logic emitStb;
  } cfar_strobe_t;

endpackage

// File: rtl/cfar_detect_ctrl.sv
module cfar_detect_ctrl
  import cfar_detect_pkg::*;
#(
  parameter int FRAME_LEN = 2048,
  parameter int ALPHA_W   = 8,
  parameter int GUARD_W   = 4,
  parameter int TRAIN_W   = 5,
  localparam int ADDR_W   = $clog2(FRAME_LEN),
  localparam int EXT_W    = ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         modeSel,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic [GUARD_W-1:0] guardLen,
  input  logic [TRAIN_W-1:0] trainLen,
  input  logic               inValid,
  output cfar_strobe_t       strobe,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0]  cutIdx,
  output logic [EXT_W-1:0]   offset,
  output noise_mode_e        modeLat,
  output logic [ALPHA_W-1:0] alphaLat,
  output logic               busy
);

  typedef enum logic [2:0] {
    S_FILL, S_CLEAR, S_ACC, S_CROSS, S_PICK, S_CMP, S_EMIT
  } ctrl_state_e;

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_LEN - 1);

  ctrl_state_e state, nextState;
  logic [TRAIN_W-1:0] kCnt;
  logic [GUARD_W-1:0] guardLat;
  logic [TRAIN_W-1:0] trainLat;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_FILL: begin
        if (inValid) begin
          strobe.wrEn = 1'b1;
          if (wrAddr == LAST) nextState = S_CLEAR;
        end
      end
      S_CLEAR: begin
        strobe.clearAcc = 1'b1;
        nextState = (trainLat == '0) ? S_CROSS : S_ACC;
      end
      S_ACC: begin
        strobe.accumulate = 1'b1;
        if (kCnt == trainLat - TRAIN_W'(1)) nextState = S_CROSS;
      end
      S_CROSS: begin
        strobe.crossStb = 1'b1;
        nextState = S_PICK;
      end
      S_PICK: begin
        strobe.pickStb = 1'b1;
        nextState = S_CMP;
      end
      S_CMP: begin
        strobe.cmpStb = 1'b1;
        nextState = S_EMIT;
      end
      S_EMIT: begin
        strobe.emitStb = 1'b1;
        nextState = (cutIdx == LAST) ? S_FILL : S_CLEAR;
      end
      default: nextState = S_FILL;
    endcase
    if (!enable) begin
      strobe    = '0;
      nextState = S_FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_FILL;
      wrAddr   <= '0;
      cutIdx   <= '0;
      kCnt     <= '0;
      guardLat <= '0;
      trainLat <= '0;
      modeLat  <= MODE_AVG;
      alphaLat <= '0;
    end else begin
      state <= nextState;
      if (!enable) begin
        wrAddr <= '0;
      end else if (strobe.wrEn) begin
        wrAddr <= (wrAddr == LAST) ? '0 : wrAddr + ADDR_W'(1);
        if (wrAddr == LAST) begin
          cutIdx   <= '0;
          guardLat <= guardLen;
          trainLat <= trainLen;
          modeLat  <= noise_mode_e'(modeSel);
          alphaLat <= alpha;
        end
      end
      if (strobe.clearAcc) kCnt <= '0;
      else if (strobe.accumulate) kCnt <= kCnt + TRAIN_W'(1);
      if (strobe.emitStb && cutIdx != LAST) cutIdx <= cutIdx + ADDR_W'(1);
    end
  end

  assign offset = EXT_W'(guardLat) + EXT_W'(kCnt) + EXT_W'(1);
  assign busy   = (state != S_FILL);

  a_r3_no_write_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.wrEn);

  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

  a_r2_first_cell_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (cutIdx == '0));

endmodule

// File: rtl/cfar_detect_dp.sv
module cfar_detect_dp
  import cfar_detect_pkg::*;
#(
  parameter int FRAME_LEN  = 2048,
  parameter int MAG_W      = 17,
  parameter int ALPHA_W    = 8,
  parameter int ALPHA_FRAC = 4,
  parameter int TRAIN_W    = 5,
  localparam int ADDR_W    = $clog2(FRAME_LEN),
  localparam int EXT_W     = ADDR_W + 2,
  localparam int SUM_W     = MAG_W + TRAIN_W,
  localparam int PROD_W    = SUM_W + TRAIN_W,
  localparam int CNT2_W    = TRAIN_W + 1,
  localparam int SUM2_W    = SUM_W + 1,
  localparam int CMP_W     = MAG_W + TRAIN_W + 1 + ALPHA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfar_strobe_t       strobe,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [MAG_W-1:0]   inMag,
  input  logic [ADDR_W-1:0]  cutIdx,
  input  logic [EXT_W-1:0]   offset,
  input  noise_mode_e        modeLat,
  input  logic [ALPHA_W-1:0] alphaLat,
  output logic               outValid,
  output logic               outHit,
  output logic [ADDR_W-1:0]  outIndex
);

  localparam logic [EXT_W-1:0] LEN_E = EXT_W'(FRAME_LEN);

  logic [MAG_W-1:0] frameMem [FRAME_LEN];

  logic [EXT_W-1:0]   cutE, lagE, leadE;
  logic               leadOk, lagOk;
  logic [SUM_W-1:0]   leadSum, lagSum;
  logic [TRAIN_W-1:0] leadCnt, lagCnt;
  logic [PROD_W-1:0]  prodLead, prodLag;
  logic [SUM2_W-1:0]  bothSum, selSum;
  logic [CNT2_W-1:0]  bothCnt, selCnt;
  logic [MAG_W-1:0]   cutMag;
  logic [CMP_W-1:0]   lhs, rhs;
  logic               useLead;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) frameMem[wrAddr] <= inMag;
  end

  assign cutE   = EXT_W'(cutIdx);
  assign leadOk = (cutE >= offset);
  assign leadE  = cutE - offset;
  assign lagE   = cutE + offset;
  assign lagOk  = (lagE < LEN_E);

  always_comb begin
    case (modeLat)
      MODE_MAX: useLead = (prodLead >= prodLag);
      MODE_MIN: useLead = (prodLead <= prodLag);
      default:  useLead = 1'b0;
    endcase
    if (leadCnt == '0) useLead = 1'b0;
    else if (lagCnt == '0) useLead = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leadSum  <= '0;
      lagSum   <= '0;
      leadCnt  <= '0;
      lagCnt   <= '0;
      prodLead <= '0;
      prodLag  <= '0;
      bothSum  <= '0;
      bothCnt  <= '0;
      cutMag   <= '0;
      selSum   <= '0;
      selCnt   <= '0;
      lhs      <= '0;
      rhs      <= '0;
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outIndex <= '0;
    end else begin
      if (strobe.clearAcc) begin
        leadSum <= '0;
        lagSum  <= '0;
        leadCnt <= '0;
        lagCnt  <= '0;
      end else if (strobe.accumulate) begin
        if (leadOk) begin
          leadSum <= leadSum + SUM_W'(frameMem[leadE[ADDR_W-1:0]]);
          leadCnt <= leadCnt + TRAIN_W'(1);
        end
        if (lagOk) begin
          lagSum <= lagSum + SUM_W'(frameMem[lagE[ADDR_W-1:0]]);
          lagCnt <= lagCnt + TRAIN_W'(1);
        end
      end
      if (strobe.crossStb) begin
        prodLead <= PROD_W'(leadSum) * PROD_W'(lagCnt);
        prodLag  <= PROD_W'(lagSum) * PROD_W'(leadCnt);
        bothSum  <= SUM2_W'(leadSum) + SUM2_W'(lagSum);
        bothCnt  <= CNT2_W'(leadCnt) + CNT2_W'(lagCnt);
        cutMag   <= frameMem[cutIdx];
      end
      if (strobe.pickStb) begin
        if (modeLat == MODE_MAX || modeLat == MODE_MIN) begin
          selSum <= useLead ? SUM2_W'(leadSum) : SUM2_W'(lagSum);
          selCnt <= useLead ? CNT2_W'(leadCnt) : CNT2_W'(lagCnt);
        end else begin
          selSum <= bothSum;
          selCnt <= bothCnt;
        end
      end
      if (strobe.cmpStb) begin
        lhs <= (CMP_W'(cutMag) * CMP_W'(selCnt)) << ALPHA_FRAC;
        rhs <= CMP_W'(alphaLat) * CMP_W'(selSum);
      end
      outValid <= strobe.emitStb;
      outHit   <= strobe.emitStb && (lhs > rhs);
      if (strobe.emitStb) outIndex <= cutIdx;
    end
  end

  a_r2_single_emit: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r5_acc_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accumulate && lagOk) |-> (lagE[ADDR_W-1:0] > cutIdx));

  a_r9_no_cells_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmpStb && selCnt == '0) |=> (lhs == '0));

endmodule

// File: rtl/cfar_detect.sv
module cfar_detect
  import cfar_detect_pkg::*;
#(
  parameter int FRAME_LEN  = 2048,
  parameter int MAG_W      = 17,
  parameter int ALPHA_W    = 8,
  parameter int ALPHA_FRAC = 4,
  parameter int GUARD_W    = 4,
  parameter int TRAIN_W    = 5,
  localparam int ADDR_W    = $clog2(FRAME_LEN),
  localparam int EXT_W     = ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         modeSel,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic [GUARD_W-1:0] guardLen,
  input  logic [TRAIN_W-1:0] trainLen,
  input  logic               inValid,
  input  logic [MAG_W-1:0]   inMag,
  output logic               busy,
  output logic               outValid,
  output logic               outHit,
  output logic [ADDR_W-1:0]  outIndex
);

  cfar_strobe_t       strobe;
  logic [ADDR_W-1:0]  wrAddr, cutIdx;
  logic [EXT_W-1:0]   offset;
  noise_mode_e        modeLat;
  logic [ALPHA_W-1:0] alphaLat;

  cfar_detect_ctrl #(
    .FRAME_LEN(FRAME_LEN), .ALPHA_W(ALPHA_W),
    .GUARD_W(GUARD_W), .TRAIN_W(TRAIN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .alpha(alpha), .guardLen(guardLen), .trainLen(trainLen),
    .inValid(inValid), .strobe(strobe), .wrAddr(wrAddr),
    .cutIdx(cutIdx), .offset(offset), .modeLat(modeLat),
    .alphaLat(alphaLat), .busy(busy)
  );

  cfar_detect_dp #(
    .FRAME_LEN(FRAME_LEN), .MAG_W(MAG_W), .ALPHA_W(ALPHA_W),
    .ALPHA_FRAC(ALPHA_FRAC), .TRAIN_W(TRAIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .inMag(inMag), .cutIdx(cutIdx), .offset(offset),
    .modeLat(modeLat), .alphaLat(alphaLat), .outValid(outValid),
    .outHit(outHit), .outIndex(outIndex)
  );

endmodule

// File: tb/cfar_detect_bench.sv
`timescale 1ns/1ps
module cfar_detect_bench;

  localparam int N      = 64;
  localparam int MAG_W  = 12;
  localparam int AW     = 8;
  localparam int GW     = 3;
  localparam int TW     = 4;
  localparam int ADDR_W = $clog2(N);

  // pattern, guard, train, mode, alpha
  localparam int NVEC = 8;
  localparam int VEC [NVEC][5] = '{
    '{0, 1, 4, 0, 48},
    '{1, 2, 3, 0, 40},
    '{3, 1, 4, 1, 40},
    '{3, 1, 4, 2, 40},
    '{2, 0, 2, 1, 56},
    '{2, 3, 6, 2, 24},
    '{0, 2, 8, 3, 32},
    '{1, 0, 1, 0, 20}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] modeSel = '0;
  logic [AW-1:0] alpha = '0;
  logic [GW-1:0] guardLen = '0;
  logic [TW-1:0] trainLen = '0;
  logic inValid = 1'b0;
  logic [MAG_W-1:0] inMag = '0;
  logic busy, outValid, outHit;
  logic [ADDR_W-1:0] outIndex;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int gotCnt = 0;
  bit gotHit [N];
  int gotIdx [N];
  int refMag [N];
  bit seenValid = 0;

  always #2 clk = ~clk;

  cfar_detect #(
    .FRAME_LEN(N), .MAG_W(MAG_W), .ALPHA_W(AW), .ALPHA_FRAC(4),
    .GUARD_W(GW), .TRAIN_W(TW)
  ) u_cfar_detect (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .alpha(alpha), .guardLen(guardLen), .trainLen(trainLen),
    .inValid(inValid), .inMag(inMag), .busy(busy),
    .outValid(outValid), .outHit(outHit), .outIndex(outIndex)
  );

  always @(negedge clk) begin
    if (outValid) begin
      seenValid = 1;
      if (gotCnt < N) begin
        gotHit[gotCnt] = outHit;
        gotIdx[gotCnt] = int'(outIndex);
      end
      gotCnt = gotCnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  function automatic int patVal(input int p, input int i);
    case (p)
      0: return (i % 13 == 5) ? 400 : 100;
      1: return i * 7 + ((i % 5 == 0) ? 300 : 0);
      2: return ((i * 37 + 11) % 97) * 3 + ((i % 17 == 3) ? 900 : 0);
      3: begin
        if (i == 20) return 300;
        if (i == 50) return 1500;
        return (i < 32) ? 60 + (i % 3) * 5 : 600 + (i % 4) * 10;
      end
      default: return (i == 30) ? 100 : (i == 40) ? 101 : 50;
    endcase
  endfunction

  function automatic bit expHit(input int c, input int g, input int t,
                                input int m, input int a);
    longint ls = 0, rs = 0, lc = 0, rc = 0, s, n;
    bit lead;
    for (int k = g + 1; k <= g + t; k++) begin
      if (c - k >= 0) begin ls += refMag[c - k]; lc++; end
      if (c + k < N)  begin rs += refMag[c + k]; rc++; end
    end
    if (m == 1 || m == 2) begin
      if (lc == 0) lead = 0;
      else if (rc == 0) lead = 1;
      else if (m == 1) lead = (ls * rc >= rs * lc);
      else lead = (ls * rc <= rs * lc);
      s = lead ? ls : rs;
      n = lead ? lc : rc;
    end else begin
      s = ls + rs;
      n = lc + rc;
    end
    return (longint'(refMag[c]) * n * 16) > (longint'(a) * s);
  endfunction

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic runFrame(input int p, input int g, input int t, input int m,
                          input int a, input bit junk, input bit midChange,
                          input string tag);
    waitIdle();
    @(negedge clk);
    modeSel  = 2'(m);
    alpha    = AW'(a);
    guardLen = GW'(g);
    trainLen = TW'(t);
    gotCnt   = 0;
    for (int i = 0; i < N; i++) refMag[i] = patVal(p, i);
    for (int i = 0; i < N; i++) begin
      inValid = 1'b1;
      inMag   = MAG_W'(refMag[i]);
      @(negedge clk);
    end
    inValid = 1'b0;
    check(busy == 1'b1, "R2 busy after full frame", int'(busy), 1);
    if (midChange) begin
      alpha    = '0;
      modeSel  = 2'((m + 1) % 3);
      trainLen = '0;
    end
    if (junk) begin
      for (int j = 0; j < 20; j++) begin
        inValid = 1'b1;
        inMag   = MAG_W'(4095 - j);
        @(negedge clk);
      end
      inValid = 1'b0;
    end
    while (gotCnt < N) @(negedge clk);
    repeat (4) @(negedge clk);
    check(gotCnt == N, "R2 result count", gotCnt, N);
    check(busy == 1'b0, "R2 busy cleared after pass", int'(busy), 0);
    for (int i = 0; i < N; i++) begin
      bit e;
      e = expHit(i, g, t, m, a);
      checks = checks + 1;
      if (gotIdx[i] != i || gotHit[i] != e) begin
        errors = errors + 1;
        $display("FAIL %s R4 R5 R8 cell %0d: actual idx %0d hit %0d expected idx %0d hit %0d",
                 tag, i, gotIdx[i], gotHit[i], i, e);
      end
    end
  endtask

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // R1: samples with enable low are not stored
    seenValid = 0;
    for (int i = 0; i < N + 5; i++) begin
      inValid = 1'b1;
      inMag   = MAG_W'(i);
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 disabled stays idle", int'(busy), 0);
    check(seenValid == 0, "R1 disabled emits nothing", int'(seenValid), 0);

    // R1: partial frame then enable drop discards it
    enable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      inValid = 1'b1;
      inMag   = MAG_W'(2000);
      @(negedge clk);
    end
    inValid = 1'b0;
    enable  = 1'b0;
    @(negedge clk);
    enable  = 1'b1;
    runFrame(0, 1, 4, 0, 48, 0, 0, "R1 restart");

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      runFrame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, 0,
               (VEC[v][3] == 1 || VEC[v][3] == 2) ? "R7" : "R6");
    end

    // R3: input while busy is ignored, here and in the next frame
    runFrame(2, 1, 3, 0, 36, 1, 0, "R3 junk frame");
    runFrame(1, 1, 3, 0, 36, 0, 0, "R3 following frame");

    // R8: strict compare at equality
    runFrame(4, 0, 2, 0, 32, 0, 0, "R8");
    check(gotHit[30] == 1'b0, "R8 equal to threshold is no hit", int'(gotHit[30]), 0);
    check(gotHit[40] == 1'b1, "R8 just above threshold hits", int'(gotHit[40]), 1);

    // R9: zero training cells
    runFrame(0, 1, 0, 0, 0, 0, 0, "R9");
    hits = 0;
    for (int i = 0; i < N; i++) hits += int'(gotHit[i]);
    check(hits == 0, "R9 no hits without training cells", hits, 0);

    // R10: settings changed during pass have no effect
    runFrame(3, 1, 4, 1, 40, 0, 1, "R10");

    // R5: edge counts with wide window
    runFrame(2, 2, 7, 2, 30, 0, 0, "R5");

    // R1: disabling during a pass returns to idle
    waitIdle();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      inValid = 1'b1;
      inMag   = MAG_W'(5);
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (10) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R1 disable aborts pass", int'(busy), 0);
    enable = 1'b1;
    runFrame(1, 0, 3, 2, 24, 0, 0, "R1 after abort");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule